// File: doc/BRIEF.md
# Timed-Access Guarded Register Bank

This block holds a small set of configuration and status registers that software may change only through a timed unlock. An unlock key register accepts every write. When the key value 0xAA is written while the unlock window is closed, a window counter opens for a fixed number of executed instructions. If the key register then holds 0x55 while the window is still open, the next writes to the guarded registers may change their protected bits as well. Outside such a window, a write changes only the freely writable bits. Some bits of each register can never be written at all.

Five guarded registers are provided: a memory configuration register, a partition control register, a checksum control register, a power control register and an interrupt priority register. At reset, the first three load masked values from bootstrap inputs. A power-fail event input sets a warning flag in the power control register, and a read of that register clears the flag. A two-bit memory range code is derived from the memory configuration and partition control registers and drives the memory partitioning logic outside the block.

Writes arrive on a valid/ready channel. `wr_ready` is always high, so there is no back-pressure: every cycle with `wr_valid` high performs exactly one write. Reads are plain: `rd_data` follows `rd_addr` combinationally, and `rd_en` marks a read that has side effects.

Top module: `tguard_regs`

## Requirements
- R1: A synchronous active-low reset clears the key register, the window counter, the power control register and the interrupt priority register. It loads memory configuration with `boot_mem & 0xFB`, partition control with `boot_part & 0x01` and checksum control with `boot_chk & 0xF0`.
- R2: A write of 0xAA to the key register (address 0) loads the window counter with 6 only when the counter is zero. While the counter is nonzero, an 0xAA write does not reload it. A load takes precedence over a tick in the same cycle.
- R3: On every cycle with `instr_tick` high, the window counter decrements by one. It stays at zero once it gets there, and a guarded write after the window has run out is not granted.
- R4: A guarded write is granted when the window counter is nonzero and the key register currently holds 0x55. A granted write loads every bit inside the writable mask from `wr_data`.
- R5: A write that is not granted changes only the bits that are inside the writable mask and outside the timed mask. Addresses and (timed, writable) masks are:
  - memory configuration: address 1, (0x0F, 0xF7)
  - partition control: address 2, (0xEF, 0xFE)
  - checksum control: address 3, (0xFF, 0x0F)
  - power control: address 4, (0xB9, 0xFF)
  - interrupt priority: address 5, (0x7F, 0xFF)
- R6: Bits outside a register's writable mask never change after reset, whether or not the write is granted.
- R7: The key register accepts every write unconditionally, and it reads back on address 0.
- R8: A `pfw_evt` pulse sets bit 5 of the power control register in the next cycle. A read with `rd_en` high at address 4 clears that bit in the next cycle. When both happen in the same cycle, the set wins. The read data shows the value held before the clear.
- R9: `range_code` is {memory configuration bit 3, partition control bit 0}.
- R10: `wr_ready` is always 1. Writes with `wr_valid` low, or to addresses 6 and 7, change nothing. Reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_mem | input | 8 | Bootstrap value for memory configuration |
| boot_part | input | 8 | Bootstrap value for partition control |
| boot_chk | input | 8 | Bootstrap value for checksum control |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| instr_tick | input | 1 | One pulse per executed instruction |
| rd_en | input | 1 | Read with side effects |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Read data for rd_addr |
| pfw_evt | input | 1 | Power-fail warning event |
| key_q | output | 8 | Key register contents |
| mem_cfg_q | output | 8 | Memory configuration register |
| part_ctl_q | output | 8 | Partition control register |
| chk_ctl_q | output | 8 | Checksum control register |
| pwr_ctl_q | output | 8 | Power control register |
| irq_pri_q | output | 8 | Interrupt priority register |
| range_code | output | 2 | Memory range code |

## Verification
On every cycle, the assertions check the following: the window counter stays in bounds, loads on an unlock, steps down on ticks and holds at zero; the key register follows its writes; never-writable bits are frozen; locked bits hold through ungranted writes; granted writes land; and the power-fail flag sets and clears. Only the bench scenarios can show the sequence-level behaviour. That covers a window that runs out after exactly six ticks, an 0xAA written into an open window that does not extend it, a key of the wrong value inside an open window, and precedence of the flag over a simultaneous read. It also covers reset loading from two different bootstrap patterns.

// File: rtl/tguard_pkg.sv
package tguard_pkg;
  localparam int SLOT_W      = 3;
  localparam int NUM_GUARDED = 5;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_KEY  = 3'd0,
    SLOT_MEM  = 3'd1,
    SLOT_PART = 3'd2,
    SLOT_CHK  = 3'd3,
    SLOT_PWR  = 3'd4,
    SLOT_PRI  = 3'd5
  } slot_e;
endpackage

// File: rtl/tg_window.sv
module tg_window #(
  parameter int                DATA_W    = 8,
  parameter int                WIN_LEN   = 6,
  parameter logic [DATA_W-1:0] KEY_OPEN  = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_GRANT = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              tick,
  output logic [DATA_W-1:0] key_q,
  output logic              grant
);
  localparam int CNT_W = $clog2(WIN_LEN + 1);

  logic [CNT_W-1:0] win_q, win_d;
  logic             open_req;

  assign open_req = key_wr && (key_data == KEY_OPEN) && (win_q == '0);

  always_comb begin
    if (open_req)                   win_d = CNT_W'(WIN_LEN);
    else if (tick && win_q != '0)   win_d = win_q - 1'b1;
    else                            win_d = win_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= '0;
      key_q <= '0;
    end else begin
      win_q <= win_d;
      if (key_wr) key_q <= key_data;
    end
  end

  assign grant = (win_q != '0) && (key_q == KEY_GRANT);

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    win_q <= CNT_W'(WIN_LEN)); // R3
  AST_WIN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_data == KEY_OPEN && win_q == '0) |=> (win_q == CNT_W'(WIN_LEN))); // R2
  AST_WIN_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != '0 && !tick) |=> (win_q == $past(win_q))); // R2
  AST_WIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && win_q != '0) |=> (win_q == $past(win_q) - 1'b1)); // R3
  AST_WIN_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == '0 && !(key_wr && key_data == KEY_OPEN)) |=> (win_q == '0)); // R3
  AST_KEY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> (key_q == $past(key_data))); // R7
endmodule

// File: rtl/tg_guard_reg.sv
module tg_guard_reg #(
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] TA_MASK  = 8'h00,
  parameter logic [DATA_W-1:0] WR_MASK  = 8'hFF,
  parameter logic [DATA_W-1:0] RST_MASK = 8'h00,
  parameter bit                HAS_FLAG = 1'b0,
  parameter int                FLAG_POS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] boot_val,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              grant,
  input  logic              rd_hit,
  input  logic              flag_set,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] FLAG_M = HAS_FLAG ? (DATA_W'(1) << FLAG_POS) : '0;
  localparam logic [DATA_W-1:0] LOCK_M = TA_MASK & WR_MASK & ~FLAG_M;
  localparam logic [DATA_W-1:0] LAND_M = WR_MASK & ~FLAG_M;

  logic [DATA_W-1:0] lock_bits, cand, wr_next, d;

  always_comb begin
    lock_bits = grant ? '0 : TA_MASK;
    cand      = (q & lock_bits) | (wr_data & ~lock_bits);
    cand      = (q & ~WR_MASK) | (cand & WR_MASK);
    wr_next   = wr_hit ? cand : q;
  end

  generate
    if (HAS_FLAG) begin : g_flag
      always_comb begin
        d = wr_next;
        if (rd_hit)   d[FLAG_POS] = 1'b0;
        if (flag_set) d[FLAG_POS] = 1'b1;
      end

      AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        flag_set |=> q[FLAG_POS]); // R8
      AST_FLAG_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !flag_set) |=> !q[FLAG_POS]); // R8
    end else begin : g_plain
      logic unused_flag_inputs;
      assign unused_flag_inputs = rd_hit ^ flag_set;
      assign d = wr_next;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) q <= boot_val & RST_MASK;
    else        q <= d;
  end

  AST_FIXED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & ~WR_MASK) == ($past(q) & ~WR_MASK))); // R6
  AST_LOCKED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !grant) |=> ((q & LOCK_M) == ($past(q) & LOCK_M))); // R5
  AST_GRANTED_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && grant) |=> ((q & LAND_M) == ($past(wr_data) & LAND_M))); // R4
endmodule

// File: rtl/tg_read_mux.sv
module tg_read_mux
  import tguard_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3,
  parameter int NREG   = 5
) (
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic [DATA_W-1:0]           key_q,
  input  logic [NREG-1:0][DATA_W-1:0] prot_q,
  output logic [DATA_W-1:0]           rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(SLOT_KEY)) rd_data = key_q;
    for (int i = 0; i < NREG; i++) begin
      if (rd_addr == ADDR_W'(i + 1)) rd_data = prot_q[i];
    end
  end
endmodule

// File: rtl/tguard_regs.sv
module tguard_regs
  import tguard_pkg::*;
#(
  parameter int                DATA_W    = 8,
  parameter int                ADDR_W    = 3,
  parameter int                WIN_LEN   = 6,
  parameter logic [DATA_W-1:0] KEY_OPEN  = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_GRANT = 8'h55,
  parameter int                FLAG_POS  = 5,
  parameter logic [NUM_GUARDED*DATA_W-1:0] TA_MASKS  = {8'h7F, 8'hB9, 8'hFF, 8'hEF, 8'h0F},
  parameter logic [NUM_GUARDED*DATA_W-1:0] WR_MASKS  = {8'hFF, 8'hFF, 8'h0F, 8'hFE, 8'hF7},
  parameter logic [NUM_GUARDED*DATA_W-1:0] RST_MASKS = {8'h00, 8'h00, 8'hF0, 8'h01, 8'hFB}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] boot_mem,
  input  logic [DATA_W-1:0] boot_part,
  input  logic [DATA_W-1:0] boot_chk,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              instr_tick,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pfw_evt,
  output logic [DATA_W-1:0] key_q,
  output logic [DATA_W-1:0] mem_cfg_q,
  output logic [DATA_W-1:0] part_ctl_q,
  output logic [DATA_W-1:0] chk_ctl_q,
  output logic [DATA_W-1:0] pwr_ctl_q,
  output logic [DATA_W-1:0] irq_pri_q,
  output logic [1:0]        range_code
);
  localparam int NREG      = NUM_GUARDED;
  localparam int RANGE_HI  = 3;
  localparam int RANGE_LO  = 0;

  logic                         grant;
  logic                         key_wr;
  logic [NREG-1:0][DATA_W-1:0]  prot_q;
  logic [NREG-1:0][DATA_W-1:0]  prot_boot;

  assign wr_ready = 1'b1;
  assign key_wr   = wr_valid && wr_ready && (wr_addr == ADDR_W'(SLOT_KEY));

  assign prot_boot[0] = boot_mem;
  assign prot_boot[1] = boot_part;
  assign prot_boot[2] = boot_chk;
  assign prot_boot[3] = '0;
  assign prot_boot[4] = '0;

  tg_window #(
    .DATA_W   (DATA_W),
    .WIN_LEN  (WIN_LEN),
    .KEY_OPEN (KEY_OPEN),
    .KEY_GRANT(KEY_GRANT)
  ) u_window (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_wr  (key_wr),
    .key_data(wr_data),
    .tick    (instr_tick),
    .key_q   (key_q),
    .grant   (grant)
  );

  generate
    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
      localparam bit IS_PWR = ((gi + 1) == int'(SLOT_PWR));
      logic wr_hit, rd_hit;
      assign wr_hit = wr_valid && wr_ready && (wr_addr == ADDR_W'(gi + 1));
      assign rd_hit = rd_en && (rd_addr == ADDR_W'(gi + 1));

      tg_guard_reg #(
        .DATA_W  (DATA_W),
        .TA_MASK (TA_MASKS [gi*DATA_W +: DATA_W]),
        .WR_MASK (WR_MASKS [gi*DATA_W +: DATA_W]),
        .RST_MASK(RST_MASKS[gi*DATA_W +: DATA_W]),
        .HAS_FLAG(IS_PWR),
        .FLAG_POS(FLAG_POS)
      ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .boot_val(prot_boot[gi]),
        .wr_hit  (wr_hit),
        .wr_data (wr_data),
        .grant   (grant),
        .rd_hit  (rd_hit),
        .flag_set(pfw_evt),
        .q       (prot_q[gi])
      );
    end
  endgenerate

  tg_read_mux #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .NREG  (NREG)
  ) u_rd_mux (
    .rd_addr(rd_addr),
    .key_q  (key_q),
    .prot_q (prot_q),
    .rd_data(rd_data)
  );

  assign mem_cfg_q  = prot_q[0];
  assign part_ctl_q = prot_q[1];
  assign chk_ctl_q  = prot_q[2];
  assign pwr_ctl_q  = prot_q[3];
  assign irq_pri_q  = prot_q[4];
  assign range_code = {mem_cfg_q[RANGE_HI], part_ctl_q[RANGE_LO]};

  AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid || wr_addr > ADDR_W'(SLOT_PRI)) && !pfw_evt && !rd_en
      |=> ($stable(key_q) && $stable(mem_cfg_q) && $stable(part_ctl_q) &&
           $stable(chk_ctl_q) && $stable(pwr_ctl_q) && $stable(irq_pri_q))); // R10
endmodule

// File: tb/tguard_regs_bench.sv
`timescale 1ns/1ps
module tguard_regs_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] boot_mem, boot_part, boot_chk;
  logic       wr_valid, wr_ready;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic       instr_tick, rd_en, pfw_evt;
  logic [7:0] key_q, mem_cfg_q, part_ctl_q, chk_ctl_q, pwr_ctl_q, irq_pri_q;
  logic [1:0] range_code;

  always #2 clk = ~clk;

  tguard_regs u_tguard_regs (
    .clk(clk), .rst_n(rst_n), .boot_mem(boot_mem), .boot_part(boot_part),
    .boot_chk(boot_chk), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .instr_tick(instr_tick),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pfw_evt(pfw_evt),
    .key_q(key_q), .mem_cfg_q(mem_cfg_q), .part_ctl_q(part_ctl_q),
    .chk_ctl_q(chk_ctl_q), .pwr_ctl_q(pwr_ctl_q), .irq_pri_q(irq_pri_q),
    .range_code(range_code)
  );

  int    n_cmp = 0, n_bad = 0;
  bit    finished = 0;
  string cur_req = "R1";
  int    m_key, m_win;
  int    m_reg [1:5];
  int    tam   [1:5];
  int    wm    [1:5];
  int    rd_seen;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int model_read(input int a);
    if (a == 0) return m_key;
    if (a >= 1 && a <= 5) return m_reg[a];
    return 0;
  endfunction

  task automatic compare_all();
    chk({cur_req, " key"},   int'(key_q),      m_key);
    chk({cur_req, " mem"},   int'(mem_cfg_q),  m_reg[1]);
    chk({cur_req, " part"},  int'(part_ctl_q), m_reg[2]);
    chk({cur_req, " chk"},   int'(chk_ctl_q),  m_reg[3]);
    chk({cur_req, " pwr"},   int'(pwr_ctl_q),  m_reg[4]);
    chk({cur_req, " pri"},   int'(irq_pri_q),  m_reg[5]);
    chk("R9 range",          int'(range_code), (((m_reg[1] >> 3) & 1) << 1) | (m_reg[2] & 1));
  endtask

  task automatic model_reset();
    m_key = 0; m_win = 0;
    m_reg[1] = boot_mem & 8'hFB;
    m_reg[2] = boot_part & 8'h01;
    m_reg[3] = boot_chk & 8'hF0;
    m_reg[4] = 0; m_reg[5] = 0;
  endtask

  task automatic cyc(input bit v, input int a, input int d, input bit t,
                     input bit re, input int ra, input bit pf);
    bit g; int lock, c;
    wr_valid = v; wr_addr = a[2:0]; wr_data = d[7:0]; instr_tick = t;
    rd_en = re; rd_addr = ra[2:0]; pfw_evt = pf;
    #1;
    rd_seen = int'(rd_data);
    chk({cur_req, " rd_data"}, rd_seen, model_read(ra));
    chk("R10 wr_ready", int'(wr_ready), 1);
    @(posedge clk);
    g = (m_win != 0) && (m_key == 8'h55);
    if (v && a == 0 && d == 8'hAA && m_win == 0) m_win = 6;
    else if (t && m_win > 0) m_win = m_win - 1;
    if (v) begin
      if (a == 0) m_key = d;
      else if (a >= 1 && a <= 5) begin
        lock = g ? 0 : tam[a];
        c = (m_reg[a] & lock) | (d & ~lock & 8'hFF);
        m_reg[a] = (m_reg[a] & ~wm[a] & 8'hFF) | (c & wm[a]);
      end
    end
    if (re && ra == 4) m_reg[4] = m_reg[4] & 8'hDF;
    if (pf) m_reg[4] = m_reg[4] | 8'h20;
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input int a, input int d);
    cyc(1'b1, a, d, 1'b0, 1'b0, 0, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 0, 1'b1, 1'b0, 0, 1'b0);
  endtask

  task automatic do_reset(input int bm, input int bp, input int bc);
    rst_n = 1'b0; boot_mem = bm[7:0]; boot_part = bp[7:0]; boot_chk = bc[7:0];
    wr_valid = 0; wr_addr = 0; wr_data = 0; instr_tick = 0;
    rd_en = 0; rd_addr = 0; pfw_evt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tam[1] = 8'h0F; wm[1] = 8'hF7;
    tam[2] = 8'hEF; wm[2] = 8'hFE;
    tam[3] = 8'hFF; wm[3] = 8'h0F;
    tam[4] = 8'hB9; wm[4] = 8'hFF;
    tam[5] = 8'h7F; wm[5] = 8'hFF;

    // R1 and R9: reset loads masked bootstrap values
    cur_req = "R1";
    do_reset(8'hFF, 8'hFF, 8'hFF);
    chk("R1 mem reset",  int'(mem_cfg_q), 8'hFB);
    chk("R1 part reset", int'(part_ctl_q), 8'h01);
    chk("R1 chk reset",  int'(chk_ctl_q), 8'hF0);
    chk("R1 pwr reset",  int'(pwr_ctl_q), 8'h00);
    chk("R9 range after reset", int'(range_code), 3);

    // R5: ungranted writes touch only free bits
    cur_req = "R5";
    wr(1, 8'h00);
    chk("R5 mem locked write", int'(mem_cfg_q), 8'h0B);
    wr(2, 8'hFF);
    chk("R5 part locked write", int'(part_ctl_q), 8'h11);

    // R4: unlock handshake then granted writes
    cur_req = "R4";
    wr(0, 8'hAA); wr(0, 8'h55);
    wr(1, 8'h00);
    chk("R4 R6 mem granted, bit3 frozen", int'(mem_cfg_q), 8'h08);
    wr(3, 8'hAB);
    chk("R4 chk granted", int'(chk_ctl_q), 8'hFB);
    wr(4, 8'hFF); wr(5, 8'hFF);
    chk("R4 pri granted", int'(irq_pri_q), 8'hFF);
    wr(2, 8'h00);
    chk("R6 part bit0 frozen under grant", int'(part_ctl_q), 8'h01);

    // R3: window expires after 6 ticks
    cur_req = "R3";
    ticks(6);
    wr(5, 8'h00);
    chk("R3 expired window denies", int'(irq_pri_q), 8'h7F);
    ticks(1);
    wr(0, 8'hAA); wr(0, 8'h55); ticks(5);
    wr(5, 8'h00);
    chk("R3 last window cycle grants", int'(irq_pri_q), 8'h00);
    ticks(1);
    wr(5, 8'hFF);
    chk("R3 window closed at zero", int'(irq_pri_q), 8'h80);

    // R2: 0xAA inside open window does not reload
    cur_req = "R2";
    wr(0, 8'hAA); ticks(3); wr(0, 8'hAA); wr(0, 8'h55); ticks(3);
    wr(5, 8'h7F);
    chk("R2 no reload while open", int'(irq_pri_q), 8'h00);

    // R4: wrong key in open window denies
    cur_req = "R4";
    wr(0, 8'hAA); wr(0, 8'h12);
    wr(5, 8'hFF);
    chk("R4 wrong key denies", int'(irq_pri_q), 8'h80);
    ticks(6);

    // R7: key always writable and readable
    cur_req = "R7";
    wr(0, 8'h3C);
    cyc(1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b0);
    chk("R7 key readback", rd_seen, 8'h3C);

    // R8: power-fail flag
    cur_req = "R8";
    cyc(1'b0, 0, 0, 1'b0, 1'b1, 4, 1'b0);
    chk("R8 read shows flag", rd_seen, 8'hFF);
    chk("R8 read clears flag", int'(pwr_ctl_q), 8'hDF);
    cyc(1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b1);
    chk("R8 event sets flag", int'(pwr_ctl_q), 8'hFF);
    cyc(1'b0, 0, 0, 1'b0, 1'b1, 4, 1'b1);
    chk("R8 set wins over read", int'(pwr_ctl_q), 8'hFF);

    // R10: inert writes and unmapped reads
    cur_req = "R10";
    wr(7, 8'h00); wr(6, 8'h00);
    cyc(1'b0, 1, 8'h00, 1'b0, 1'b0, 6, 1'b0);
    chk("R10 unmapped read zero", rd_seen, 0);
    chk("R10 mem untouched", int'(mem_cfg_q), 8'h08);

    // R1 and R9 with a second bootstrap pattern
    cur_req = "R1";
    do_reset(8'h0C, 8'h02, 8'h3F);
    chk("R1 mem boot2", int'(mem_cfg_q), 8'h08);
    chk("R1 part boot2", int'(part_ctl_q), 8'h00);
    chk("R1 chk boot2", int'(chk_ctl_q), 8'h30);
    chk("R9 range boot2", int'(range_code), 2);

    // mixed stimulus compared against the model every cycle (R2 R3 R4 R5 R6 R8)
    cur_req = "R4 R5 mixed";
    for (int i = 0; i < 2000; i++) begin
      int a, d, sel;
      sel = $urandom_range(0, 9);
      a = $urandom_range(0, 7);
      d = $urandom_range(0, 255);
      if (sel < 2) begin a = 0; d = 8'hAA; end
      else if (sel < 4) begin a = 0; d = 8'h55; end
      cyc($urandom_range(0, 3) != 0, a, d, $urandom_range(0, 2) == 0,
          $urandom_range(0, 4) == 0, $urandom_range(0, 7), $urandom_range(0, 9) == 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule